// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps a small set of binary tokens that two independent agents, a left port and a right port, use to agree on who may touch a shared resource. It holds no data memory. Each port issues accesses with a semaphore select, a chip enable, two byte enables, a read/write strobe, an output enable, an address and an 18-bit data bus. All of these are sampled on a common clock. A token is requested by writing 0 in data bit 0 and released by writing 1. Reading the token shows 0 to the side that holds it and 1 to everyone else.

A side that asks for a token already held by the other side is not refused outright. Its request is latched, and the token moves to it in the same clock edge at which the holder releases it. When both sides ask for a free token in the same cycle, the left side gets it. A read returns a snapshot taken in the first cycle of the read, and the snapshot holds on the bus for as long as the read stays active.

Top module: `sema_bank`

## Requirements
- R1: There are eight tokens, chosen by address bits [2:0]; address bits [12:3] have no effect on which token is accessed.
- R2: A port reaches the tokens only when its semaphore select is low and either its chip enable is high or both byte enables are high; a write with chip enable low and a byte enable low changes no token.
- R3: A write acts on data bit 0 only (0 = request, 1 = release); data bits [17:1] are ignored.
- R4: A request on a free token gives it to the requesting side: from the next cycle that side reads 0 and the other side reads 1.
- R5: Only the holder can free a token. A request from the other side stays pending and leaves both read values unchanged. The waiting side withdraws its pending request by writing 1.
- R6: When the holder releases a token while the other side has a request pending, the token passes to the waiting side at that same clock edge.
- R7: When the holder releases a token and no request is pending, both sides read 1.
- R8: Two requests for a free token in the same cycle give the token to the left side. A request made in an earlier cycle beats a later one.
- R9: During an active read (select valid, output enable low, read/write high) the token value drives all 18 data bits and rvalid is 1. With no active read, data is 0 and rvalid is 0.
- R10: The value read is captured in the first cycle of a read. It is held, whatever the token or the index does, until the select or the output enable goes inactive.
- R11: After reset, all eight tokens are free and read 1 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_ub_ni | input | 1 | Left upper byte enable, active low |
| l_lb_ni | input | 1 | Left lower byte enable, active low |
| l_we_ni | input | 1 | Left read/write, low = write |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 13 | Left address, bits [2:0] pick the token |
| l_wdata_i | input | 18 | Left write data, bit 0 used |
| l_rdata_o | output | 18 | Left read data |
| l_rvalid_o | output | 1 | Left read active |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_ub_ni | input | 1 | Right upper byte enable, active low |
| r_lb_ni | input | 1 | Right lower byte enable, active low |
| r_we_ni | input | 1 | Right read/write, low = write |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 13 | Right address, bits [2:0] pick the token |
| r_wdata_i | input | 18 | Right write data, bit 0 used |
| r_rdata_o | output | 18 | Right read data |
| r_rvalid_o | output | 1 | Right read active |

## Verification
Directed sequences walk one token through claim, blocked request, hand-off, withdrawal and free. This separates a pending request that carries over from one that is dropped, and a hand-off from a plain release. Same-cycle requests and staggered requests from the two sides separate the tie rule from the earlier-wins rule. A read held open across a hand-off and an index change shows whether the output is a frozen snapshot or a live view. Random bursts then mix valid and invalid selects, junk upper address and data bits and concurrent writes from both sides, and a reference model checks every token from both sides.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 18,
  parameter int IDX_W  = 3
) (
  input  logic              sem_ni,
  input  logic              ce_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_o,
  output logic              wbit_o,
  output logic              rd_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic sel;
  logic unused_bits;

  // token space: select low, memory side not enabled
  assign sel    = ~sem_ni & (ce_ni | (ub_ni & lb_ni));
  assign wr_o   = sel & ~we_ni;
  assign rd_o   = sel & we_ni & ~oe_ni;
  assign wbit_o = wdata_i[0];
  assign idx_o  = addr_i[IDX_W-1:0];

  assign unused_bits = ^{addr_i[ADDR_W-1:IDX_W], wdata_i[DATA_W-1:1]};
endmodule

// File: rtl/sema_flag.sv
module sema_flag
  import sema_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_wr_i,
  input  logic l_bit_i,
  input  logic r_wr_i,
  input  logic r_bit_i,
  output logic l_val_o,
  output logic r_val_o
);
  logic req_l_q, req_r_q, req_l_d, req_r_d;
  own_e own_q, own_d;

  always_comb begin
    req_l_d = l_wr_i ? l_bit_i : req_l_q;
    req_r_d = r_wr_i ? r_bit_i : req_r_q;
    own_d   = own_q;
    unique case (own_q)
      OWN_LEFT:  if (req_l_d) own_d = req_r_d ? OWN_NONE : OWN_RIGHT;
      OWN_RIGHT: if (req_r_d) own_d = req_l_d ? OWN_NONE : OWN_LEFT;
      default: begin
        if (!req_l_d)      own_d = OWN_LEFT;   // left wins a tie
        else if (!req_r_d) own_d = OWN_RIGHT;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  assign l_val_o = (own_q != OWN_LEFT);
  assign r_val_o = (own_q != OWN_RIGHT);

  // R5: holder keeps token unless it releases
  a_r5_holder_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_LEFT && !(l_wr_i && l_bit_i)) |=> (own_q == OWN_LEFT));
  // R6: release with pending request hands over
  a_r6_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_LEFT && l_wr_i && l_bit_i && !req_r_q && !(r_wr_i && r_bit_i))
    |=> (own_q == OWN_RIGHT));
  // R7: release without pending request frees
  a_r7_release_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_RIGHT && r_wr_i && r_bit_i && req_l_q && !(l_wr_i && !l_bit_i))
    |=> (l_val_o && r_val_o));
  // R8: same-cycle requests on a free token favour left
  a_r8_tie_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_NONE && l_wr_i && !l_bit_i && r_wr_i && !r_bit_i)
    |=> (!l_val_o && r_val_o));
endmodule

// File: rtl/sema_rd_hold.sv
module sema_rd_hold #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 18,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o
);
  logic act_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cap_q <= 1'b1;
    end else begin
      act_q <= rd_i;
      if (rd_i && !act_q) cap_q <= flags_i[idx_i];
    end
  end

  assign rdata_o  = act_q ? {DATA_W{cap_q}} : '0;
  assign rvalid_o = act_q;

  // R10: output frozen while read stays active
  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 18,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_ni,
  input  logic              l_ce_ni,
  input  logic              l_ub_ni,
  input  logic              l_lb_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  input  logic              r_sem_ni,
  input  logic              r_ce_ni,
  input  logic              r_ub_ni,
  input  logic              r_lb_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o
);
  logic             l_wr, l_wbit, l_rd, r_wr, r_wbit, r_rd;
  logic [IDX_W-1:0] l_idx, r_idx;
  logic [NUM_FLAGS-1:0] l_flags, r_flags;

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_l (
    .sem_ni(l_sem_ni), .ce_ni(l_ce_ni), .ub_ni(l_ub_ni), .lb_ni(l_lb_ni),
    .we_ni(l_we_ni), .oe_ni(l_oe_ni), .addr_i(l_addr_i), .wdata_i(l_wdata_i),
    .wr_o(l_wr), .wbit_o(l_wbit), .rd_o(l_rd), .idx_o(l_idx)
  );

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_r (
    .sem_ni(r_sem_ni), .ce_ni(r_ce_ni), .ub_ni(r_ub_ni), .lb_ni(r_lb_ni),
    .we_ni(r_we_ni), .oe_ni(r_oe_ni), .addr_i(r_addr_i), .wdata_i(r_wdata_i),
    .wr_o(r_wr), .wbit_o(r_wbit), .rd_o(r_rd), .idx_o(r_idx)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sema_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .l_wr_i  (l_wr && (l_idx == IDX_W'(f))),
      .l_bit_i (l_wbit),
      .r_wr_i  (r_wr && (r_idx == IDX_W'(f))),
      .r_bit_i (r_wbit),
      .l_val_o (l_flags[f]),
      .r_val_o (r_flags[f])
    );
  end

  sema_rd_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(l_rd), .idx_i(l_idx),
    .flags_i(l_flags), .rdata_o(l_rdata_o), .rvalid_o(l_rvalid_o)
  );

  sema_rd_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(r_rd), .idx_i(r_idx),
    .flags_i(r_flags), .rdata_o(r_rdata_o), .rvalid_o(r_rvalid_o)
  );

  // R9: a held read always shows a replicated bit
  a_r9_replicated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rvalid_o |-> (l_rdata_o == '0 || l_rdata_o == '1));
endmodule

// File: tb/sema_bank_tb_top.sv
`timescale 1ns/1ps
module sema_bank_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni, l_we_ni, l_oe_ni;
  logic [12:0] l_addr_i;
  logic [17:0] l_wdata_i, l_rdata_o;
  logic        l_rvalid_o;
  logic        r_sem_ni, r_ce_ni, r_ub_ni, r_lb_ni, r_we_ni, r_oe_ni;
  logic [12:0] r_addr_i;
  logic [17:0] r_wdata_i, r_rdata_o;
  logic        r_rvalid_o;

  sema_bank dut_i (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int own_m [8];   // 0 free, 1 left, 2 right
  bit reql_m [8];
  bit reqr_m [8];
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_val(input bit right, input int f);
    return right ? (own_m[f] != 2) : (own_m[f] != 1);
  endfunction

  function automatic bit sel_ok(input logic s, input logic c, input logic u, input logic b);
    return !s && (c || (u && b));
  endfunction

  task automatic model_step();
    bit lw, rw;
    int li, ri;
    lw = sel_ok(l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni) && !l_we_ni;
    rw = sel_ok(r_sem_ni, r_ce_ni, r_ub_ni, r_lb_ni) && !r_we_ni;
    li = int'(l_addr_i[2:0]);
    ri = int'(r_addr_i[2:0]);
    for (int f = 0; f < 8; f++) begin
      if (lw && li == f) reql_m[f] = l_wdata_i[0];
      if (rw && ri == f) reqr_m[f] = r_wdata_i[0];
      if (own_m[f] == 1 && reql_m[f]) own_m[f] = reqr_m[f] ? 0 : 2;
      else if (own_m[f] == 2 && reqr_m[f]) own_m[f] = reql_m[f] ? 0 : 1;
      else if (own_m[f] == 0) begin
        if (!reql_m[f]) own_m[f] = 1;
        else if (!reqr_m[f]) own_m[f] = 2;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle_all();
    {l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni, l_we_ni, l_oe_ni} = 6'b111111;
    {r_sem_ni, r_ce_ni, r_ub_ni, r_lb_ni, r_we_ni, r_oe_ni} = 6'b111111;
  endtask

  task automatic set_wr(input bit right, input int f, input logic [17:0] d, input logic [9:0] hi);
    if (!right) begin
      {l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni, l_we_ni, l_oe_ni} = 6'b010101;
      l_addr_i = {hi, 3'(f)}; l_wdata_i = d;
    end else begin
      {r_sem_ni, r_ce_ni, r_ub_ni, r_lb_ni, r_we_ni, r_oe_ni} = 6'b010101;
      r_addr_i = {hi, 3'(f)}; r_wdata_i = d;
    end
  endtask

  task automatic set_rd(input bit right, input int f, input logic [9:0] hi);
    if (!right) begin
      {l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni, l_we_ni, l_oe_ni} = 6'b010010;
      l_addr_i = {hi, 3'(f)};
    end else begin
      {r_sem_ni, r_ce_ni, r_ub_ni, r_lb_ni, r_we_ni, r_oe_ni} = 6'b010010;
      r_addr_i = {hi, 3'(f)};
    end
  endtask

  task automatic wr1(input bit right, input int f, input logic [17:0] d);
    idle_all(); set_wr(right, f, d, 10'h2A5); tick(); idle_all();
  endtask

  task automatic rd_both(input string tag, input int fl, input int fr);
    bit el, er;
    el = exp_val(1'b0, fl); er = exp_val(1'b1, fr);
    idle_all();
    set_rd(1'b0, fl, 10'($urandom)); set_rd(1'b1, fr, 10'($urandom));
    tick();
    chk({tag, " left"},  {13'd0, l_rvalid_o, l_rdata_o}, {13'd0, 1'b1, {18{el}}});
    chk({tag, " right"}, {13'd0, r_rvalid_o, r_rdata_o}, {13'd0, 1'b1, {18{er}}});
    idle_all(); tick();
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    idle_all();
    l_addr_i = '0; r_addr_i = '0; l_wdata_i = '1; r_wdata_i = '1;
    for (int f = 0; f < 8; f++) begin own_m[f] = 0; reql_m[f] = 1; reqr_m[f] = 1; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 idle outputs, R11 reset state
    chk("R9 idle left",  {13'd0, l_rvalid_o, l_rdata_o}, 32'd0);
    chk("R9 idle right", {13'd0, r_rvalid_o, r_rdata_o}, 32'd0);
    for (int f = 0; f < 8; f++) rd_both("R11 reset free", f, f);

    // R1 R4: claim token 3 with junk high address bits
    wr1(1'b0, 3, 18'h3FFFE);
    rd_both("R4 claim", 3, 3);
    chk("R4 left holds", {31'd0, exp_val(1'b0, 3)}, 32'd0);
    rd_both("R1 other tokens untouched", 4, 2);

    // R5: blocked request stays pending
    wr1(1'b1, 3, 18'h0);
    rd_both("R5 blocked", 3, 3);
    // R6: handoff on release
    wr1(1'b0, 3, 18'h1);
    rd_both("R6 handoff", 3, 3);
    chk("R6 right holds", {31'd0, exp_val(1'b1, 3)}, 32'd0);
    // R7: release with nothing pending
    wr1(1'b1, 3, 18'h1);
    rd_both("R7 free", 3, 3);

    // R8: same-cycle tie on token 5
    idle_all(); set_wr(1'b0, 5, 18'h0, 10'h0); set_wr(1'b1, 5, 18'h0, 10'h3FF); tick();
    rd_both("R8 tie left", 5, 5);
    // R8: earlier request wins on token 6
    wr1(1'b1, 6, 18'h0);
    wr1(1'b0, 6, 18'h0);
    rd_both("R8 earlier right", 6, 6);

    // R3: upper data bits ignored
    wr1(1'b0, 2, 18'h2AAAA);
    rd_both("R3 bit0 request", 2, 2);
    wr1(1'b0, 2, 18'h00001);
    rd_both("R3 bit0 release", 2, 2);

    // R2: memory-side access does not touch tokens
    idle_all();
    {l_sem_ni, l_ce_ni, l_ub_ni, l_lb_ni, l_we_ni, l_oe_ni} = 6'b000101;
    l_addr_i = 13'd1; l_wdata_i = 18'h0;
    tick(); idle_all();
    rd_both("R2 ignored write", 1, 1);

    // R10: snapshot frozen across handoff and index change
    // token 5 held by left, right requested in tie above (pending)
    idle_all(); set_rd(1'b1, 5, 10'h0); tick();
    chk("R10 capture", {14'd0, r_rdata_o}, {14'd0, 18'h3FFFF});
    set_wr(1'b0, 5, 18'h1, 10'h0); tick();
    {l_sem_ni, l_we_ni} = 2'b11;
    tick();
    chk("R10 frozen after handoff", {14'd0, r_rdata_o}, {14'd0, 18'h3FFFF});
    r_addr_i = 13'd2; tick();
    chk("R10 frozen after index change", {14'd0, r_rdata_o}, {14'd0, 18'h3FFFF});
    idle_all(); tick();
    rd_both("R10 fresh read", 5, 5);
    chk("R10 right now holds", {31'd0, exp_val(1'b1, 5)}, 32'd0);

    // R5 withdraw: left requests then withdraws, right releases
    wr1(1'b0, 5, 18'h0);
    wr1(1'b0, 5, 18'h1);
    wr1(1'b1, 5, 18'h1);
    rd_both("R5 withdraw", 5, 5);

    // random mix
    for (int i = 0; i < 400; i++) begin
      idle_all();
      l_sem_ni = ($urandom % 4) == 0; l_ce_ni = 1'($urandom); l_ub_ni = 1'($urandom);
      l_lb_ni = 1'($urandom); l_we_ni = ($urandom % 3) == 0; l_oe_ni = 1'b1;
      l_addr_i = 13'($urandom); l_wdata_i = 18'($urandom);
      r_sem_ni = ($urandom % 4) == 0; r_ce_ni = 1'($urandom); r_ub_ni = 1'($urandom);
      r_lb_ni = 1'($urandom); r_we_ni = ($urandom % 3) == 0; r_oe_ni = 1'b1;
      r_addr_i = 13'($urandom); r_wdata_i = 18'($urandom);
      tick();
      rd_both("R4-R8 random", int'($urandom % 8), int'($urandom % 8));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule